// File: doc/BRIEF.md
# Audio Sample Buffer for an 8-bit Parallel Bus

This peripheral sits on a simple 8-bit host bus with active-low strobes. It accepts waveform bytes from the host and hands them to a parallel DAC at a steady sample rate. Host writes and DAC loads are decoupled through an internal queue. When the block's select line and the write strobe are low together, the byte on the data lines enters the queue. When the select line and the read strobe are low together, the block drives a status byte that reports the queue's fill state. It releases the data lines at all other times.

A sample tick from elsewhere in the clock domain removes the oldest byte and places it on the DAC data lines. One cycle later the block pulses the DAC load strobe, so the converter only captures data that has already settled. An empty queue blocks the tick, so the converter never receives a stale or undefined word. Both bus strobes are synchronised into the block clock. The write strobe is edge-detected, so one strobe assertion stores exactly one byte.

Top module: `audio_sample_buffer`

## Requirements
- R1: A write takes effect while `bus_sel_n` and `bus_wr_n` are both low. The byte on `bus_din` is queued once per assertion of that condition, however many cycles the condition lasts. It is queued within SYNC_STAGES+1 clock cycles of the condition first appearing.
- R2: `bus_doe` is high only while `bus_sel_n` and `bus_rd_n` are both low, delayed by SYNC_STAGES cycles. While `bus_doe` is high, `bus_dout` carries the status byte.
- R3: The status byte sets bit 0 when the queue is empty, bit 2 when it holds at least DEPTH/2 entries, and bit 3 when it holds DEPTH entries. Bits 1 and 4 to 7 are always zero. The status register refreshes on every clock.
- R4: A `sample_tick` with a non-empty queue removes one entry. The entry appears on `dac_data` after that clock edge. `dac_load` then goes high for exactly one cycle, starting one cycle later, and `dac_data` does not change while the strobe is high.
- R5: A `sample_tick` with an empty queue produces no `dac_load` pulse and leaves `dac_data` unchanged.
- R6: A write to a full queue is dropped. The stored entries and the full status do not change.
- R7: `rst_n` low or `bus_mreset` high at a clock edge empties the queue, sets `dac_data` to 0, drops `dac_load` and `bus_doe`, and makes the status read 0x01.
- R8: Entries reach `dac_data` in the order in which they were written.
- R9: A `sample_tick` in the cycle right after an accepted tick is ignored.
- R10: Write or read strobes with `bus_sel_n` high neither queue a byte nor drive the data lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_mreset | input | 1 | Bus master reset, active high, sampled synchronously |
| bus_sel_n | input | 1 | Module select for this block, active low |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| bus_rd_n | input | 1 | Bus read strobe, active low |
| bus_din | input | 8 | Data lines as driven by the host |
| bus_dout | output | 8 | Status byte toward the data lines |
| bus_doe | output | 1 | Enables the block's drive onto the data lines |
| sample_tick | input | 1 | One-cycle sample-rate pulse |
| dac_data | output | 8 | Sample word for the DAC |
| dac_load | output | 1 | DAC load strobe, one cycle wide |

## Verification
The bound checker checks every cycle that the status byte keeps its reserved bits at zero and never reports full together with empty, or full without half-full. It also checks that the load strobe lasts one cycle over steady DAC data, and that the bus drive enable follows only a selected read. Queue order, the one-push-per-strobe rule, drops on overflow, suppression of the strobe on an empty queue, the ignored back-to-back tick and both reset sources depend on data history. Only the bench's scenarios can show these, by filling, overfilling and draining the queue and comparing each popped byte with the byte that was written.

// File: rtl/asb_pkg.sv
// Shared constants for the audio sample buffer.
// Assumes an 8-bit status byte; only the bit positions are fixed here.
package asb_pkg;
    localparam int STATUS_W    = 8;
    localparam int ST_EMPTY    = 0;
    localparam int ST_HALF     = 2;
    localparam int ST_FULL     = 3;

    // Assemble the status byte from the queue flags.
    function automatic logic [STATUS_W-1:0] pack_status(input logic empty,
                                                        input logic half,
                                                        input logic full);
        logic [STATUS_W-1:0] s;
        s           = '0;
        s[ST_EMPTY] = empty;
        s[ST_HALF]  = half;
        s[ST_FULL]  = full;
        return s;
    endfunction
endpackage

// File: rtl/asb_strobe_sync.sv
// Multi-stage synchroniser for one level signal from the bus side.
// Assumes the input is held for longer than STAGES clock cycles.
module asb_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clear,
    input  logic async_in,
    output logic level
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop capture.
            always_ff @(posedge clk) begin
                if (clear) chain <= '0;
                else       chain <= async_in;
            end
        end else begin : g_multi
            // Shift chain capture.
            always_ff @(posedge clk) begin
                if (clear) chain <= '0;
                else       chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign level = chain[STAGES-1];
endmodule

// File: rtl/asb_fifo.sv
// Single-clock circular queue with level counter and fill flags.
// Assumes DEPTH is a power of two, at least 2. Overflowing pushes and
// underflowing pops are ignored.
module asb_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              empty,
    output logic              half,
    output logic              full
);
    localparam int            AW     = $clog2(DEPTH);
    localparam logic [AW:0]   FULL_C = (AW+1)'(DEPTH);
    localparam logic [AW:0]   HALF_C = (AW+1)'(DEPTH / 2);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [AW:0]       fill;
    logic              do_push;
    logic              do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (!clear && do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign rdata = mem[rd_ptr];
    assign empty = (fill == '0);
    assign full  = (fill == FULL_C);
    assign half  = (fill >= HALF_C);
endmodule

// File: rtl/asb_dac_seq.sv
// Converts sample ticks into queue pops and a delayed DAC load strobe.
// Assumes sample_tick is synchronous to clk. Data is presented one cycle
// before the strobe; a tick during that settle cycle is ignored.
module asb_dac_seq #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              clear,
    input  logic              tick,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_rdata,
    output logic              pop,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_load
);
    logic pend;

    assign pop = tick && !fifo_empty && !pend;

    // Capture popped word, then strobe one cycle later.
    always_ff @(posedge clk) begin
        if (clear) begin
            dac_data <= '0;
            pend     <= 1'b0;
            dac_load <= 1'b0;
        end else begin
            pend     <= pop;
            dac_load <= pend;
            if (pop) dac_data <= fifo_rdata;
        end
    end
endmodule

// File: rtl/audio_sample_buffer.sv
// Top level: bus decode, strobe synchronisation, queue, status register
// and DAC sequencing. Assumes bus_din is steady while the write strobe is
// active and that host strobes last longer than SYNC_STAGES+1 cycles.
module audio_sample_buffer #(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_mreset,
    input  logic              bus_sel_n,
    input  logic              bus_wr_n,
    input  logic              bus_rd_n,
    input  logic [7:0]        bus_din,
    output logic [7:0]        bus_dout,
    output logic              bus_doe,
    input  logic              sample_tick,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_load
);
    import asb_pkg::*;

    logic                clear;
    logic                wr_raw;
    logic                rd_raw;
    logic                wr_lvl;
    logic                rd_lvl;
    logic                wr_lvl_q;
    logic                push;
    logic                pop;
    logic [DATA_W-1:0]   q_rdata;
    logic                q_empty;
    logic                q_half;
    logic                q_full;
    logic [STATUS_W-1:0] status_q;

    assign clear  = !rst_n || bus_mreset;
    assign wr_raw = !bus_sel_n && !bus_wr_n;
    assign rd_raw = !bus_sel_n && !bus_rd_n;

    asb_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk      (clk),
        .clear    (clear),
        .async_in (wr_raw),
        .level    (wr_lvl)
    );

    asb_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk      (clk),
        .clear    (clear),
        .async_in (rd_raw),
        .level    (rd_lvl)
    );

    // Delay for write edge detection.
    always_ff @(posedge clk) begin
        if (clear) wr_lvl_q <= 1'b0;
        else       wr_lvl_q <= wr_lvl;
    end

    assign push = wr_lvl && !wr_lvl_q;

    asb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .clear (clear),
        .push  (push),
        .wdata (bus_din[DATA_W-1:0]),
        .pop   (pop),
        .rdata (q_rdata),
        .empty (q_empty),
        .half  (q_half),
        .full  (q_full)
    );

    asb_dac_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .clear      (clear),
        .tick       (sample_tick),
        .fifo_empty (q_empty),
        .fifo_rdata (q_rdata),
        .pop        (pop),
        .dac_data   (dac_data),
        .dac_load   (dac_load)
    );

    // Status snapshot refreshed every cycle.
    always_ff @(posedge clk) begin
        if (clear) status_q <= pack_status(1'b1, 1'b0, 1'b0);
        else       status_q <= pack_status(q_empty, q_half, q_full);
    end

    assign bus_dout = status_q;
    assign bus_doe  = rd_lvl;
endmodule

// File: rtl/asb_checker.sv
// Cycle-level properties of the audio sample buffer, observed at its ports.
// Assumes the default two-stage strobe synchroniser.
module asb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_mreset,
    input logic       bus_sel_n,
    input logic       bus_rd_n,
    input logic [7:0] bus_dout,
    input logic       bus_doe,
    input logic [7:0] dac_data,
    input logic       dac_load
);
    AST_STATUS_RESERVED: assert property (@(posedge clk) disable iff (!rst_n || bus_mreset)
        (bus_dout & 8'hF2) == 8'h00);                                     // R3
    AST_EMPTY_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n || bus_mreset)
        !(bus_dout[0] && bus_dout[3]));                                   // R3
    AST_FULL_HAS_HALF: assert property (@(posedge clk) disable iff (!rst_n || bus_mreset)
        bus_dout[3] |-> bus_dout[2]);                                     // R3
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n || bus_mreset)
        dac_load |=> !dac_load);                                          // R4
    AST_LOAD_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n || bus_mreset)
        dac_load |-> $stable(dac_data));                                  // R4
    AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n || bus_mreset)
        bus_doe |-> $past(!bus_sel_n && !bus_rd_n, 2));                   // R2
endmodule

bind audio_sample_buffer asb_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_mreset (bus_mreset),
    .bus_sel_n  (bus_sel_n),
    .bus_rd_n   (bus_rd_n),
    .bus_dout   (bus_dout),
    .bus_doe    (bus_doe),
    .dac_data   (dac_data),
    .dac_load   (dac_load)
);

// File: tb/sim_audio_sample_buffer.sv
// Self-checking bench: a vector table walked in one loop, then directed
// tests for selection, back-to-back ticks, full queue and master reset.
module sim_audio_sample_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int DEPTH      = 256;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;
    localparam int NVEC = 13;
    // {op, arg, expected}; for ticks arg=1 means a load strobe is expected.
    localparam logic [17:0] VEC [NVEC] = '{
        {OP_RD, 8'h00, 8'h01},
        {OP_WR, 8'h11, 8'h00},
        {OP_WR, 8'h22, 8'h00},
        {OP_WR, 8'h33, 8'h00},
        {OP_RD, 8'h00, 8'h00},
        {OP_TK, 8'h01, 8'h11},
        {OP_TK, 8'h01, 8'h22},
        {OP_TK, 8'h01, 8'h33},
        {OP_RD, 8'h00, 8'h01},
        {OP_TK, 8'h00, 8'h33},
        {OP_WR, 8'hA5, 8'h00},
        {OP_RD, 8'h00, 8'h00},
        {OP_TK, 8'h01, 8'hA5}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_mreset = 1'b0;
    logic       bus_sel_n = 1'b1;
    logic       bus_wr_n = 1'b1;
    logic       bus_rd_n = 1'b1;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout;
    logic       bus_doe;
    logic       sample_tick = 1'b0;
    logic [7:0] dac_data;
    logic       dac_load;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_sample_buffer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_mreset  (bus_mreset),
        .bus_sel_n   (bus_sel_n),
        .bus_wr_n    (bus_wr_n),
        .bus_rd_n    (bus_rd_n),
        .bus_din     (bus_din),
        .bus_dout    (bus_dout),
        .bus_doe     (bus_doe),
        .sample_tick (sample_tick),
        .dac_data    (dac_data),
        .dac_load    (dac_load)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] b, input logic sel_n);
        @(negedge clk);
        bus_din = b; bus_sel_n = sel_n; bus_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_wr_n = 1'b1; bus_sel_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_read(input logic sel_n, output logic [7:0] st, output logic oe);
        @(negedge clk);
        bus_sel_n = sel_n; bus_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        st = bus_dout; oe = bus_doe;
        bus_rd_n = 1'b1; bus_sel_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_status(input string req, input logic [7:0] exp);
        logic [7:0] st;
        logic       oe;
        bus_read(1'b0, st, oe);
        chk(req, {7'd0, oe}, 8'h01);
        chk(req, st, exp);
    endtask

    task automatic tick_check(input string req, input logic [7:0] exp, input logic load_exp);
        logic [7:0] d;
        logic       l0, l1, l2;
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        d = dac_data; l0 = dac_load;
        @(negedge clk);
        l1 = dac_load;
        @(negedge clk);
        l2 = dac_load;
        chk(req, d, exp);
        chk(req, {5'd0, l0, l1, l2}, {5'd0, 1'b0, load_exp, 1'b0});
    endtask

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] st;
        logic       oe;
        int         loads;
        repeat (4) @(negedge clk);
        // R7: state under reset
        chk("R7 reset dac_data", dac_data, 8'h00);
        chk("R7 reset strobes", {6'd0, dac_load, bus_doe}, 8'h00);
        chk("R7 reset status", bus_dout, 8'h01);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table: R1 R2 R3 R4 R5 R8
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][17:16])
                OP_WR: bus_write(VEC[i][15:8], 1'b0);
                OP_RD: read_status("R2 R3 vector status", VEC[i][7:0]);
                default: tick_check("R4 R5 R8 vector tick", VEC[i][7:0], VEC[i][8]);
            endcase
        end

        // R10: strobes without select
        bus_write(8'h99, 1'b1);
        read_status("R10 unselected write", 8'h01);
        bus_read(1'b1, st, oe);
        chk("R10 unselected read drive", {7'd0, oe}, 8'h00);
        tick_check("R10 no byte queued", 8'hA5, 1'b0);

        // R1: one long strobe stores one byte
        @(negedge clk);
        bus_din = 8'h3C; bus_sel_n = 1'b0; bus_wr_n = 1'b0;
        repeat (20) @(negedge clk);
        bus_wr_n = 1'b1; bus_sel_n = 1'b1;
        repeat (4) @(negedge clk);
        tick_check("R1 long strobe pop", 8'h3C, 1'b1);
        read_status("R1 single push only", 8'h01);

        // R9: tick held two cycles pops once
        bus_write(8'h5A, 1'b0);
        bus_write(8'h6B, 1'b0);
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sample_tick = 1'b0;
        loads = 0;
        for (int k = 0; k < 5; k++) begin
            if (dac_load) loads++;
            @(negedge clk);
        end
        chk("R9 one load for adjacent ticks", 8'(loads), 8'h01);
        chk("R9 first value", dac_data, 8'h5A);
        read_status("R9 one entry left", 8'h00);
        tick_check("R9 second value", 8'h6B, 1'b1);

        // R3 R6: fill to half, full, then overflow
        for (int k = 0; k < DEPTH; k++) begin
            bus_write(8'(k), 1'b0);
            if (k == DEPTH/2 - 2) read_status("R3 below half", 8'h00);
            if (k == DEPTH/2 - 1) read_status("R3 half full", 8'h04);
        end
        read_status("R3 full", 8'h0C);
        bus_write(8'hEE, 1'b0);
        read_status("R6 still full after overflow write", 8'h0C);
        for (int k = 0; k < DEPTH; k++) begin
            tick_check("R6 R8 drain order", 8'(k), 1'b1);
            if (k == 0) read_status("R3 full cleared", 8'h04);
        end
        read_status("R6 empty after drain", 8'h01);
        tick_check("R5 empty tick keeps data", 8'hFF, 1'b0);

        // R7: master reset clears queue and DAC word
        bus_write(8'h77, 1'b0);
        tick_check("R7 pre-reset pop", 8'h77, 1'b1);
        bus_write(8'h78, 1'b0);
        @(negedge clk);
        bus_mreset = 1'b1;
        repeat (2) @(negedge clk);
        bus_mreset = 1'b0;
        chk("R7 master reset dac_data", dac_data, 8'h00);
        read_status("R7 master reset status", 8'h01);
        tick_check("R7 queue emptied", 8'h00, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule